// File: doc/BRIEF.md
# Receive Frame Phase Sequencer

This block is the sub-state machine that runs while a radio receives a single frame. A start pulse given while the sequencer is inactive launches a frame. The sequencer then times each phase of the frame in turn: the access address, an optional coded-PHY FEC1 block, the payload and the CRC. At each phase boundary it raises single-cycle event pulses in a fixed order. Demodulation, address matching and CRC arithmetic happen elsewhere. Their results reach this block as flags and a length value, and it samples each of them at the boundary where it is needed.

When the address phase ends, the sequencer checks the received length and a coding-indicator validity flag. A packet that fails this check ends the frame at once and raises a reject flag. A stop or disable request aborts a frame that is in progress. Durations are cycle counts. The payload duration is the received length multiplied by a per-byte cycle count.

Top module: `rx_frame_seq`

## Requirements
- R1: A start pulse while inactive begins a frame, and `busy_o` is high from the next clock edge until the frame ends. A start pulse while busy is ignored.
- R2: `ev_sync_o`, `ev_address_o` and `ev_frame_start_o` pulse together for one cycle. They appear max(addr_cycles,1) cycles after the edge that accepted the start.
- R3: At the address end, the packet is rejected if length > max length, if `ci_bad_i` is high, or if length is 0 while `mode154_i` is high. A rejected packet pulses `ev_reject_o` in the same cycle as the address events and drops `busy_o` in that cycle. It produces no rate-boost, payload, end, PHY-end or CRC event.
- R4: `max_len_i`, `mode154_i` and `coded_i` are sampled at start. Changes to them during the frame have no effect.
- R5: With coding selected, an FEC1 phase of max(fec1_cycles,1) cycles follows the address. At its end, `ev_rateboost_o` pulses if `rateboost_i` is high. Without coding, `ev_rateboost_o` never pulses.
- R6: `ev_payload_o` pulses max(len*byte_cycles,1) cycles after the end of the previous phase (address, or FEC1 when coding is selected).
- R7: `ev_end_o` and `ev_phyend_o` pulse max(crc_cycles,1) cycles after the payload end. In the same cycle exactly one of `ev_crcok_o` (when `crc_ok_i` is high) or `ev_crcerr_o` pulses, and `busy_o` falls.
- R8: A stop or disable request sampled while busy returns the sequencer to inactive at that edge. It takes priority over a phase end in the same cycle, and no event of that frame follows.
- R9: A phase duration of zero lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin receiving a frame |
| stop_i | input | 1 | Abort the frame |
| disable_i | input | 1 | Abort the frame |
| coded_i | input | 1 | Coded PHY selected (sampled at start) |
| mode154_i | input | 1 | 802.15.4 mode selected (sampled at start) |
| max_len_i | input | LEN_W | Largest accepted length (sampled at start) |
| len_i | input | LEN_W | Received length (sampled at address end) |
| ci_bad_i | input | 1 | Coding indicator corrupted (sampled at address end) |
| rateboost_i | input | 1 | Rate-boost condition (sampled at FEC1 end) |
| crc_ok_i | input | 1 | CRC result (sampled at CRC end) |
| addr_cycles_i | input | CNT_W | Address phase duration |
| fec1_cycles_i | input | CNT_W | FEC1 phase duration |
| byte_cycles_i | input | CNT_W | Cycles per payload byte |
| crc_cycles_i | input | CNT_W | CRC phase duration |
| busy_o | output | 1 | Frame in progress |
| ev_sync_o | output | 1 | Sync event |
| ev_address_o | output | 1 | Address event |
| ev_frame_start_o | output | 1 | Frame-start event |
| ev_reject_o | output | 1 | Packet rejected |
| ev_rateboost_o | output | 1 | Rate-boost event |
| ev_payload_o | output | 1 | Payload end event |
| ev_end_o | output | 1 | Frame end event |
| ev_phyend_o | output | 1 | PHY end event |
| ev_crcok_o | output | 1 | CRC good |
| ev_crcerr_o | output | 1 | CRC bad |

## Verification
The hardest case to reach is a stop or disable that lands in the very cycle a phase would end. In that cycle the abort must win, and no event may leak out. The bench counts edges from the accepted start. It then raises disable exactly in the last cycle of the address phase, a cycle it knows from the programmed duration. A second hard case is a change to the sampled mode inputs in the middle of a frame. The bench flips them right after start and checks that rejection and phase timing still follow the values that were present at start.

// File: rtl/rx_seq_pkg.sv
// Shared types for the receive frame phase sequencer.
// Assumes: used by rx_frame_seq and its sub-blocks only.
package rx_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_FEC1 = 3'd2,
        ST_PAY  = 3'd3,
        ST_CRC  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/rx_seq_timer.sv
// Phase down-counter: loaded with a duration, flags the last cycle.
// Assumes: a zero duration is stretched to one cycle; clear wins over counting.
module rx_seq_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] dur_i,
    input  logic         clear_i,
    output logic         last_o
);
    logic [W-1:0] rem;

    // Remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (load_i) begin
            rem <= (dur_i == '0) ? W'(1) : dur_i;
        end else if (clear_i) begin
            rem <= '0;
        end else if (rem != '0) begin
            rem <= rem - W'(1);
        end
    end

    assign last_o = (rem == W'(1));
endmodule

// File: rtl/rx_seq_accept.sv
// Packet acceptance test applied at the end of the address phase.
// Assumes: inputs are valid in the cycle the address phase ends.
module rx_seq_accept #(
    parameter int LEN_W = 8
) (
    input  logic [LEN_W-1:0] len_i,
    input  logic [LEN_W-1:0] max_len_i,
    input  logic             ci_bad_i,
    input  logic             mode154_i,
    output logic             reject_o
);
    logic too_long;
    logic empty_154;

    // Flag each rejection cause and merge them.
    always_comb begin
        too_long  = (len_i > max_len_i);
        empty_154 = mode154_i && (len_i == '0);
        reject_o  = too_long || ci_bad_i || empty_154;
    end
endmodule

// File: rtl/rx_frame_seq.sv
// Receive frame phase sequencer: times address, optional FEC1, payload and
// CRC phases and pulses ordered events at each boundary.
// Assumes: start is honoured only while inactive; all events are one-cycle
// registered pulses; abort requests act only while busy.
module rx_frame_seq
    import rx_seq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             disable_i,
    input  logic             coded_i,
    input  logic             mode154_i,
    input  logic [LEN_W-1:0] max_len_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             ci_bad_i,
    input  logic             rateboost_i,
    input  logic             crc_ok_i,
    input  logic [CNT_W-1:0] addr_cycles_i,
    input  logic [CNT_W-1:0] fec1_cycles_i,
    input  logic [CNT_W-1:0] byte_cycles_i,
    input  logic [CNT_W-1:0] crc_cycles_i,
    output logic             busy_o,
    output logic             ev_sync_o,
    output logic             ev_address_o,
    output logic             ev_frame_start_o,
    output logic             ev_reject_o,
    output logic             ev_rateboost_o,
    output logic             ev_payload_o,
    output logic             ev_end_o,
    output logic             ev_phyend_o,
    output logic             ev_crcok_o,
    output logic             ev_crcerr_o
);
    localparam int PAY_W = LEN_W + CNT_W;

    seq_state_t       state;
    logic             coded_q;
    logic             mode154_q;
    logic [LEN_W-1:0] max_len_q;
    logic [LEN_W-1:0] len_q;
    logic             abort;
    logic             last;
    logic             reject;
    logic             tmr_load;
    logic [PAY_W-1:0] tmr_dur;
    logic [LEN_W-1:0] len_src;
    logic [PAY_W-1:0] pay_dur;

    rx_seq_timer #(.W(PAY_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .dur_i   (tmr_dur),
        .clear_i (abort),
        .last_o  (last)
    );

    rx_seq_accept #(.LEN_W(LEN_W)) u_accept (
        .len_i     (len_i),
        .max_len_i (max_len_q),
        .ci_bad_i  (ci_bad_i),
        .mode154_i (mode154_q),
        .reject_o  (reject)
    );

    // Payload length comes live at the address end, held afterwards.
    always_comb begin
        len_src = (state == ST_ADDR) ? len_i : len_q;
        pay_dur = PAY_W'(len_src) * PAY_W'(byte_cycles_i);
    end

    // Abort condition and timer load for the next phase.
    always_comb begin
        abort    = (state != ST_IDLE) && (stop_i || disable_i);
        tmr_load = 1'b0;
        tmr_dur  = '0;
        unique case (state)
            ST_IDLE: if (start_i) begin
                tmr_load = 1'b1;
                tmr_dur  = PAY_W'(addr_cycles_i);
            end
            ST_ADDR: if (last && !abort && !reject) begin
                tmr_load = 1'b1;
                tmr_dur  = coded_q ? PAY_W'(fec1_cycles_i) : pay_dur;
            end
            ST_FEC1: if (last && !abort) begin
                tmr_load = 1'b1;
                tmr_dur  = pay_dur;
            end
            ST_PAY: if (last && !abort) begin
                tmr_load = 1'b1;
                tmr_dur  = PAY_W'(crc_cycles_i);
            end
            default: ;
        endcase
    end

    // Phase state, sampled frame settings and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state            <= ST_IDLE;
            coded_q          <= 1'b0;
            mode154_q        <= 1'b0;
            max_len_q        <= '0;
            len_q            <= '0;
            ev_sync_o        <= 1'b0;
            ev_address_o     <= 1'b0;
            ev_frame_start_o <= 1'b0;
            ev_reject_o      <= 1'b0;
            ev_rateboost_o   <= 1'b0;
            ev_payload_o     <= 1'b0;
            ev_end_o         <= 1'b0;
            ev_phyend_o      <= 1'b0;
            ev_crcok_o       <= 1'b0;
            ev_crcerr_o      <= 1'b0;
        end else begin
            ev_sync_o        <= 1'b0;
            ev_address_o     <= 1'b0;
            ev_frame_start_o <= 1'b0;
            ev_reject_o      <= 1'b0;
            ev_rateboost_o   <= 1'b0;
            ev_payload_o     <= 1'b0;
            ev_end_o         <= 1'b0;
            ev_phyend_o      <= 1'b0;
            ev_crcok_o       <= 1'b0;
            ev_crcerr_o      <= 1'b0;
            if (abort) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: if (start_i) begin
                        state     <= ST_ADDR;
                        coded_q   <= coded_i;
                        mode154_q <= mode154_i;
                        max_len_q <= max_len_i;
                    end
                    ST_ADDR: if (last) begin
                        ev_sync_o        <= 1'b1;
                        ev_address_o     <= 1'b1;
                        ev_frame_start_o <= 1'b1;
                        len_q            <= len_i;
                        if (reject) begin
                            ev_reject_o <= 1'b1;
                            state       <= ST_IDLE;
                        end else begin
                            state <= coded_q ? ST_FEC1 : ST_PAY;
                        end
                    end
                    ST_FEC1: if (last) begin
                        ev_rateboost_o <= rateboost_i;
                        state          <= ST_PAY;
                    end
                    ST_PAY: if (last) begin
                        ev_payload_o <= 1'b1;
                        state        <= ST_CRC;
                    end
                    ST_CRC: if (last) begin
                        ev_end_o    <= 1'b1;
                        ev_phyend_o <= 1'b1;
                        ev_crcok_o  <= crc_ok_i;
                        ev_crcerr_o <= !crc_ok_i;
                        state       <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/rx_frame_seq_chk.sv
// Property checker for rx_frame_seq, attached with bind below.
// Assumes: port names match the sequencer's port names.
module rx_frame_seq_chk #(
    parameter int LEN_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic             disable_i,
    input logic             busy_o,
    input logic             ev_sync_o,
    input logic             ev_address_o,
    input logic             ev_frame_start_o,
    input logic             ev_reject_o,
    input logic             ev_rateboost_o,
    input logic             ev_payload_o,
    input logic             ev_end_o,
    input logic             ev_phyend_o,
    input logic             ev_crcok_o,
    input logic             ev_crcerr_o
);
    logic [LEN_W+CNT_W-1:0] unused_width;
    assign unused_width = '0;

    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    a_r2_addr_group: assert property (@(posedge clk) disable iff (!rst_n)
        ev_address_o |-> (ev_sync_o && ev_frame_start_o));

    a_r3_reject_ends: assert property (@(posedge clk) disable iff (!rst_n)
        ev_reject_o |-> (ev_address_o && !busy_o && !ev_payload_o && !ev_end_o));

    a_r5_boost_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rateboost_o |-> (busy_o && !ev_address_o));

    a_r7_crc_one: assert property (@(posedge clk) disable iff (!rst_n)
        ev_end_o |-> (ev_phyend_o && ($countones({ev_crcok_o, ev_crcerr_o}) == 1) && !busy_o));

    a_r7_crc_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_crcok_o || ev_crcerr_o) |-> ev_end_o);

    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (stop_i || disable_i)) |=>
        (!busy_o && !ev_address_o && !ev_payload_o && !ev_end_o && !ev_rateboost_o));
endmodule

bind rx_frame_seq rx_frame_seq_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/rx_frame_seq_bench.sv
// Directed bench for rx_frame_seq: one task per scenario.
module rx_frame_seq_bench;
    localparam int LEN_W = 8;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, disable_i = 0, coded_i = 0, mode154_i = 0;
    logic [LEN_W-1:0] max_len_i = 0, len_i = 0;
    logic ci_bad_i = 0, rateboost_i = 0, crc_ok_i = 0;
    logic [CNT_W-1:0] addr_cycles_i = 0, fec1_cycles_i = 0, byte_cycles_i = 0, crc_cycles_i = 0;
    logic busy_o, ev_sync_o, ev_address_o, ev_frame_start_o, ev_reject_o, ev_rateboost_o;
    logic ev_payload_o, ev_end_o, ev_phyend_o, ev_crcok_o, ev_crcerr_o;

    rx_frame_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_rx_frame_seq (.*);

    always #2 clk = ~clk;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int n_sync, n_addr, n_fs, n_rej, n_rb, n_pay, n_end, n_phy, n_ok, n_err;
    int c_addr, c_sync, c_fs, c_rej, c_rb, c_pay, c_end;

    always @(posedge clk) cyc <= cyc + 1;

    // Event log taken away from the active edge.
    always @(negedge clk) begin
        if (ev_sync_o) begin n_sync++; c_sync = cyc; end
        if (ev_address_o) begin n_addr++; c_addr = cyc; end
        if (ev_frame_start_o) begin n_fs++; c_fs = cyc; end
        if (ev_reject_o) begin n_rej++; c_rej = cyc; end
        if (ev_rateboost_o) begin n_rb++; c_rb = cyc; end
        if (ev_payload_o) begin n_pay++; c_pay = cyc; end
        if (ev_end_o) begin n_end++; c_end = cyc; end
        if (ev_phyend_o) n_phy++;
        if (ev_crcok_o) n_ok++;
        if (ev_crcerr_o) n_err++;
    end

    task automatic clr_log();
        n_sync = 0; n_addr = 0; n_fs = 0; n_rej = 0; n_rb = 0;
        n_pay = 0; n_end = 0; n_phy = 0; n_ok = 0; n_err = 0;
        c_addr = -1; c_sync = -1; c_fs = -1; c_rej = -1; c_rb = -1; c_pay = -1; c_end = -1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int atl1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // Pulse start for one cycle; returns the cycle count of the accepting edge.
    task automatic do_start(output int t0);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        t0 = cyc;
    endtask

    task automatic setup(input int a, input int f, input int l, input int b, input int c,
                         input bit cod, input bit m154, input int ml, input bit ci,
                         input bit rb, input bit ok);
        addr_cycles_i = CNT_W'(a); fec1_cycles_i = CNT_W'(f); len_i = LEN_W'(l);
        byte_cycles_i = CNT_W'(b); crc_cycles_i = CNT_W'(c); coded_i = cod;
        mode154_i = m154; max_len_i = LEN_W'(ml); ci_bad_i = ci; rateboost_i = rb; crc_ok_i = ok;
    endtask

    // Full frame with computed expected event cycles.
    task automatic t_frame(input string tag, input int a, input int f, input int l, input int b,
                           input int c, input bit cod, input bit m154, input int ml,
                           input bit ci, input bit rb, input bit ok, input bit rej);
        int t0, ta, tp, te;
        clr_log();
        setup(a, f, l, b, c, cod, m154, ml, ci, rb, ok);
        do_start(t0);
        check("R1", {tag, " busy after start"}, int'(busy_o), 1);
        repeat (a + f + l * b + c + 10) @(negedge clk);
        ta = t0 + atl1(a);
        check("R2", {tag, " address cycle"}, c_addr, ta);
        check("R2", {tag, " sync with address"}, c_sync, ta);
        check("R2", {tag, " frame start with address"}, c_fs, ta);
        check("R1", {tag, " idle after frame"}, int'(busy_o), 0);
        if (rej) begin
            check("R3", {tag, " reject cycle"}, c_rej, ta);
            check("R3", {tag, " no payload/end/crc"}, n_pay + n_end + n_phy + n_ok + n_err + n_rb, 0);
        end else begin
            check("R3", {tag, " no reject"}, n_rej, 0);
            tp = ta + (cod ? atl1(f) : 0);
            check("R5", {tag, " rateboost count"}, n_rb, (cod && rb) ? 1 : 0);
            if (cod && rb) check("R5", {tag, " rateboost cycle"}, c_rb, tp);
            tp = tp + atl1(l * b);
            check("R6", {tag, " payload cycle"}, c_pay, tp);
            te = tp + atl1(c);
            check("R7", {tag, " end cycle"}, c_end, te);
            check("R7", {tag, " phyend count"}, n_phy, 1);
            check("R7", {tag, " crcok count"}, n_ok, ok ? 1 : 0);
            check("R7", {tag, " crcerr count"}, n_err, ok ? 0 : 1);
        end
    endtask

    task automatic t_reset();
        check("R1", "reset busy", int'(busy_o), 0);
        check("R1", "reset events", int'({ev_sync_o, ev_address_o, ev_reject_o, ev_payload_o,
                                          ev_end_o, ev_crcok_o, ev_crcerr_o}), 0);
    endtask

    // Stop during address, then disable during payload.
    task automatic t_abort();
        int t0;
        clr_log();
        setup(10, 0, 4, 3, 5, 0, 0, 50, 0, 0, 1);
        do_start(t0);
        repeat (3) @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        check("R8", "busy falls after stop", int'(busy_o), 0);
        repeat (40) @(negedge clk);
        check("R8", "no events after stop", n_addr + n_pay + n_end, 0);
        clr_log();
        setup(2, 0, 5, 4, 5, 0, 0, 50, 0, 0, 1);
        do_start(t0);
        repeat (6) @(negedge clk);
        check("R8", "address passed before disable", n_addr, 1);
        disable_i = 1'b1;
        @(negedge clk) disable_i = 1'b0;
        check("R8", "busy falls after disable", int'(busy_o), 0);
        repeat (40) @(negedge clk);
        check("R8", "no payload/end after disable", n_pay + n_end + n_ok + n_err, 0);
    endtask

    // Disable raised exactly in the last address cycle must win.
    task automatic t_abort_at_boundary();
        int t0;
        clr_log();
        setup(5, 0, 2, 2, 2, 0, 0, 50, 0, 0, 1);
        do_start(t0);
        while (cyc < t0 + 4) @(negedge clk);
        disable_i = 1'b1;
        @(negedge clk) disable_i = 1'b0;
        repeat (20) @(negedge clk);
        check("R8", "abort beats phase end", n_addr + n_sync + n_pay + n_end, 0);
        check("R8", "idle after boundary abort", int'(busy_o), 0);
    endtask

    // Second start while busy must not restart the frame.
    task automatic t_start_busy();
        int t0;
        clr_log();
        setup(6, 0, 2, 2, 3, 0, 0, 50, 0, 0, 1);
        do_start(t0);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (30) @(negedge clk);
        check("R1", "start while busy ignored (address cycle)", c_addr, t0 + 6);
        check("R1", "start while busy ignored (one end)", n_end, 1);
    endtask

    // Settings changed after start keep their start-time values.
    task automatic t_sampling();
        int t0;
        clr_log();
        setup(4, 3, 20, 1, 2, 0, 0, 10, 0, 1, 1);
        do_start(t0);
        max_len_i = 8'd255;
        repeat (30) @(negedge clk);
        check("R4", "max length held from start", n_rej, 1);
        clr_log();
        setup(4, 3, 0, 1, 2, 0, 0, 50, 0, 1, 1);
        do_start(t0);
        mode154_i = 1'b1;
        coded_i = 1'b1;
        repeat (30) @(negedge clk);
        check("R4", "mode held from start", n_rej, 0);
        check("R4", "coding held from start (payload cycle)", c_pay, t0 + 4 + 1);
        check("R4", "coding held from start (no boost)", n_rb, 0);
    endtask

    initial begin
        clr_log();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_frame("plain ok", 3, 0, 4, 2, 5, 0, 0, 40, 0, 0, 1, 0);
        t_frame("plain crc bad", 2, 0, 7, 3, 4, 0, 0, 40, 0, 1, 0, 0);
        t_frame("coded boost", 3, 6, 3, 2, 2, 1, 0, 40, 0, 1, 1, 0);
        t_frame("coded no boost", 3, 6, 3, 2, 2, 1, 0, 40, 0, 0, 0, 0);
        t_frame("reject too long", 3, 0, 41, 2, 2, 0, 0, 40, 0, 0, 1, 1);
        t_frame("accept at max", 3, 0, 40, 1, 2, 0, 0, 40, 0, 0, 1, 0);
        t_frame("reject ci", 3, 0, 5, 2, 2, 1, 0, 40, 1, 1, 1, 1);
        t_frame("reject empty 154", 3, 0, 0, 2, 2, 0, 1, 40, 0, 0, 1, 1);
        t_frame("R9 zero durations", 0, 0, 0, 0, 0, 0, 0, 40, 0, 0, 1, 0);
        t_frame("R9 zero fec1", 2, 0, 2, 2, 0, 1, 0, 40, 0, 1, 0, 0);
        t_abort();
        t_abort_at_boundary();
        t_start_busy();
        t_sampling();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule